// File: doc/BRIEF.md
# Logistic-Map Control Word Generator

This block produces a stream of 17-bit control words from a chaotic sequence. It iterates the logistic recurrence x' = mu·x·(1 − x) in fixed-point arithmetic. The state x is an unsigned 24-bit fraction. The growth factor mu has 2 integer bits and 24 fraction bits. Each new state gives one word, made from the 17 highest fraction bits of that state. A downstream scrambler consumes the words and uses the bits to pick shift directions and shift amounts.

The seeds arrive on a single parameter port, one beat after another: mu first, then x(0). Each beat can be unmasked by an XOR with a key register. The key registers start at built-in constants. After every complete seed pair they are replaced by the seeds just recovered, so each new pair is protected by the previous one. A start pulse loads the working state from the stored x(0).

The arithmetic uses one shared multiplier over two steps. The first step forms mu·x. The second step multiplies that product by (1 − x). The steps advance only on cycles where the step-enable input is high. With the enable asserted every fourth cycle, one word comes out every eight cycles.

Top module: `chaos_word_gen`

## Requirements
- R1: After reset, `wordValid` is 0 and `word` is 0.
- R2: Accepted `paramValid` beats alternate, starting with mu. Mu is taken from `paramData` as a 2.24 value. X(0) is taken from bits 23:0 of `paramData`. A `start` pulse is ignored until at least one full pair has been loaded.
- R3: Each iteration first computes t = floor(mu·x / 2^24). It then computes x' = floor(t·(2^24 − x) / 2^24).
- R4: The first word after a start comes from x(1), the state after one iteration. Each word holds bits 23:7 of the new state. Successive words follow successive iterations with no gap. `word` holds its value between valid pulses.
- R5: The sequencer moves only on cycles with `stepEn` high, and each word takes two enabled steps. With `stepEn` high every fourth cycle, `wordValid` pulses exactly 8 cycles apart, and each pulse is one cycle wide.
- R6: When `maskEn` is 1 on a beat, the stored seed is `paramData` XOR the current key; when it is 0, the stored seed is `paramData` unchanged. The keys reset to `KEY_MU` and `KEY_X`. After each completed pair, the keys take the values of the mu and x(0) just stored, whatever `maskEn` was.
- R7: A `start` pulse while running restarts the sequence from the stored x(0) and mu.
- R8: Loading seeds while running leaves the running sequence unchanged. The new seeds take effect at the next `start`.
- R9: For a legal mu (below 4), the second product never reaches 1.0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| paramValid | input | 1 | Seed beat strobe |
| paramData | input | 26 | Seed beat value (mu 2.24, or x(0) in bits 23:0) |
| maskEn | input | 1 | XOR the beat with the key register |
| start | input | 1 | Begin or restart iteration from the stored seeds |
| stepEn | input | 1 | Step enable that sets the generation rate |
| word | output | 17 | Latest control word |
| wordValid | output | 1 | One-cycle pulse when a new word is present |

## Verification
The assertions assume that the recovered mu lies between 3 and 4 and that the recovered x(0) lies strictly between 0 and 1. Under those conditions the second product stays below one. They also assume that `start` and `paramValid` are never asserted in the same cycle. The stimulus draws random mu and x(0) only from those open ranges, adds the extreme legal values as directed cases, and encodes each masked beat with the bench's own model of the key chain, so the recovered seeds are always legal. `stepEn` comes from a free-running divide-by-four counter.

// File: rtl/chaos_pkg.sv
package chaos_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_MUL1, ST_MUL2} genState_t;

  typedef struct packed {
    logic takeMu;
    logic takeX;
    logic initState;
    logic mulSecond;
    logic capProd;
    logic capState;
  } dpCtrl_t;
endpackage

// File: rtl/chaos_ctrl.sv
module chaos_ctrl
  import chaos_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    paramValid,
  input  logic    start,
  input  logic    stepEn,
  output dpCtrl_t ctl
);
  genState_t st, stNext;
  logic loadPhase;
  logic seedsReady;
  logic goNow;

  assign goNow = start && seedsReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loadPhase  <= 1'b0;
      seedsReady <= 1'b0;
    end else if (paramValid) begin
      loadPhase <= ~loadPhase;
      if (loadPhase) seedsReady <= 1'b1;
    end
  end

  always_comb begin
    stNext = st;
    if (goNow) stNext = ST_MUL1;
    else if (stepEn) begin
      case (st)
        ST_MUL1: stNext = ST_MUL2;
        ST_MUL2: stNext = ST_MUL1;
        default: stNext = st;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) st <= ST_IDLE;
    else       st <= stNext;
  end

  always_comb begin
    ctl.takeMu    = paramValid && !loadPhase;
    ctl.takeX     = paramValid && loadPhase;
    ctl.initState = goNow;
    ctl.mulSecond = (st == ST_MUL2);
    ctl.capProd   = !goNow && stepEn && (st == ST_MUL1);
    ctl.capState  = !goNow && stepEn && (st == ST_MUL2);
  end

  // R2: no iteration before a full seed pair exists
  a_r2_idle_until_loaded: assert property (@(posedge clk) disable iff (!rstN)
    !seedsReady |-> st == ST_IDLE);
  // R5: sequencer holds when the step enable is low
  a_r5_hold_without_enable: assert property (@(posedge clk) disable iff (!rstN)
    (!stepEn && !start) |=> $stable(st));
  a_r5_one_capture: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.capProd, ctl.capState, ctl.initState}));
endmodule

// File: rtl/chaos_dp.sv
module chaos_dp
  import chaos_pkg::*;
#(
  parameter int FRAC_W = 24,
  parameter int INT_W  = 2,
  parameter int WORD_W = 17,
  parameter logic [INT_W+FRAC_W-1:0] KEY_MU = 26'h1234567,
  parameter logic [FRAC_W-1:0]       KEY_X  = 24'h9ABCDE
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  dpCtrl_t                 ctl,
  input  logic [INT_W+FRAC_W-1:0] paramData,
  input  logic                    maskEn,
  output logic [WORD_W-1:0]       word,
  output logic                    wordValid
);
  localparam int MU_W   = INT_W + FRAC_W;
  localparam int OPB_W  = FRAC_W + 1;
  localparam int PROD_W = MU_W + OPB_W;
  localparam int HI_W   = PROD_W - FRAC_W;
  localparam logic [OPB_W-1:0] ONE = OPB_W'(1) << FRAC_W;

  logic [MU_W-1:0]   keyMu, muSeed, muRun, muIn, prodReg;
  logic [FRAC_W-1:0] keyX, xSeed, xCur, xIn;
  logic [MU_W-1:0]   opA;
  logic [OPB_W-1:0]  opB;
  logic [PROD_W-1:0] prod;
  logic [HI_W-1:0]   mulHi;

  assign muIn = maskEn ? (paramData ^ keyMu) : paramData;
  assign xIn  = maskEn ? (paramData[FRAC_W-1:0] ^ keyX) : paramData[FRAC_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      keyMu  <= KEY_MU;
      keyX   <= KEY_X;
      muSeed <= '0;
      xSeed  <= '0;
    end else begin
      if (ctl.takeMu) muSeed <= muIn;
      if (ctl.takeX) begin
        xSeed <= xIn;
        keyX  <= xIn;
        keyMu <= muSeed;
      end
    end
  end

  // shared multiplier, operands chosen by the step
  assign opA   = ctl.mulSecond ? prodReg : muRun;
  assign opB   = ctl.mulSecond ? (ONE - {1'b0, xCur}) : {1'b0, xCur};
  assign prod  = {{OPB_W{1'b0}}, opA} * {{MU_W{1'b0}}, opB};
  assign mulHi = prod[PROD_W-1:FRAC_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      muRun     <= '0;
      xCur      <= '0;
      prodReg   <= '0;
      word      <= '0;
      wordValid <= 1'b0;
    end else begin
      wordValid <= 1'b0;
      if (ctl.initState) begin
        muRun <= muSeed;
        xCur  <= xSeed;
      end
      if (ctl.capProd) prodReg <= mulHi[MU_W-1:0];
      if (ctl.capState) begin
        xCur      <= mulHi[FRAC_W-1:0];
        word      <= mulHi[FRAC_W-1 -: WORD_W];
        wordValid <= 1'b1;
      end
    end
  end

  // R9: with legal mu the new state is a proper fraction
  a_r9_state_below_one: assert property (@(posedge clk) disable iff (!rstN)
    ctl.capState |-> mulHi[HI_W-1:FRAC_W] == '0);
  // R5: one-cycle valid pulse
  a_r5_valid_single: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |=> !wordValid);
  // R4: word changes only together with a valid pulse
  a_r4_word_held: assert property (@(posedge clk) disable iff (!rstN)
    !wordValid |=> (wordValid || $stable(word)));
  // R6: keys follow the completed pair
  a_r6_key_chain: assert property (@(posedge clk) disable iff (!rstN)
    ctl.takeX |=> (keyX == xSeed && keyMu == muSeed));
endmodule

// File: rtl/chaos_word_gen.sv
module chaos_word_gen
  import chaos_pkg::*;
#(
  parameter int FRAC_W = 24,
  parameter int INT_W  = 2,
  parameter int WORD_W = 17,
  parameter logic [INT_W+FRAC_W-1:0] KEY_MU = 26'h1234567,
  parameter logic [FRAC_W-1:0]       KEY_X  = 24'h9ABCDE
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    paramValid,
  input  logic [INT_W+FRAC_W-1:0] paramData,
  input  logic                    maskEn,
  input  logic                    start,
  input  logic                    stepEn,
  output logic [WORD_W-1:0]       word,
  output logic                    wordValid
);
  dpCtrl_t ctl;

  chaos_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .paramValid(paramValid),
    .start(start), .stepEn(stepEn), .ctl(ctl)
  );

  chaos_dp #(
    .FRAC_W(FRAC_W), .INT_W(INT_W), .WORD_W(WORD_W),
    .KEY_MU(KEY_MU), .KEY_X(KEY_X)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .paramData(paramData),
    .maskEn(maskEn), .word(word), .wordValid(wordValid)
  );
endmodule

// File: tb/chaos_word_gen_tb.sv
module chaos_word_gen_tb;
  logic clk = 0, rstN = 0;
  logic paramValid = 0, maskEn = 0, start = 0, stepEn = 0;
  logic [25:0] paramData = '0;
  logic [16:0] word;
  logic wordValid;
  int checks = 0, fails = 0;
  int cyc = 0, lastCyc = -1;
  bit done = 0;
  logic [25:0] kMu = 26'h1234567;
  logic [23:0] kX  = 24'h9ABCDE;

  chaos_word_gen u_dut (.clk(clk), .rstN(rstN), .paramValid(paramValid),
    .paramData(paramData), .maskEn(maskEn), .start(start), .stepEn(stepEn),
    .word(word), .wordValid(wordValid));

  always #5 clk = ~clk;
  always @(posedge clk) cyc++;

  initial begin
    int c = 0;
    forever begin
      @(negedge clk);
      c++;
      stepEn = (c % 4 == 0);
    end
  end

  function automatic logic [23:0] nextX(logic [25:0] mu, logic [23:0] x);
    longint unsigned t, y;
    t = (longint'(mu) * longint'(x)) >> 24;
    y = (t * (longint'(1) << 24) - t * longint'(x)) >> 24;
    return y[23:0];
  endfunction

  task automatic chk(bit ok, string req, longint got, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  task automatic beat(logic [25:0] d, logic m);
    @(negedge clk);
    paramValid = 1; paramData = d; maskEn = m;
    @(negedge clk);
    paramValid = 0; maskEn = 0;
  endtask

  task automatic loadPair(logic [25:0] mu, logic [23:0] x, logic m);
    beat(m ? (mu ^ kMu) : mu, m);
    beat(m ? {2'b0, x ^ kX} : {2'b0, x}, m);
    kMu = mu; kX = x;
  endtask

  task automatic pulseStart();
    @(negedge clk);
    start = 1;
    @(negedge clk);
    start = 0;
    lastCyc = -1;
  endtask

  task automatic expectWords(inout logic [23:0] xe, input logic [25:0] mu, input int n);
    for (int k = 0; k < n; k++) begin
      int w = 0;
      while (!wordValid && w < 100) begin @(negedge clk); w++; end
      chk(wordValid, "R5 valid seen", wordValid, 1);
      xe = nextX(mu, xe);
      chk(word == xe[23:7], "R3/R4 word", word, xe[23:7]);
      if (lastCyc >= 0) chk(cyc - lastCyc == 8, "R5 spacing", cyc - lastCyc, 8);
      lastCyc = cyc;
      @(negedge clk);
      chk(!wordValid, "R5 pulse width", wordValid, 0);
      chk(word == xe[23:7], "R4 word held", word, xe[23:7]);
    end
  endtask

  function automatic logic [25:0] rndMu();
    return (26'd3 << 24) + 26'd1 + 26'($urandom % 32'hFFFFFE);
  endfunction
  function automatic logic [23:0] rndX();
    return 24'd1 + 24'($urandom % 32'hFFFFFE);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [23:0] xe;
    logic [25:0] muA, muB;
    logic [23:0] xA, xB;
    int seen;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(wordValid == 0 && word == 0, "R1 reset", {word, wordValid}, 0);
    rstN = 1;
    // R2: start before any seeds is ignored
    pulseStart();
    seen = 0;
    repeat (40) begin @(negedge clk); if (wordValid) seen++; end
    chk(seen == 0, "R2 start ignored", seen, 0);

    // R6: masked with built-in keys
    muA = 26'h3_C00000; xA = 24'hC00000;
    loadPair(muA, xA, 1);
    pulseStart(); xe = xA; expectWords(xe, muA, 4);
    // R6: masked with the previous pair as key
    muB = rndMu(); xB = rndX();
    loadPair(muB, xB, 1);
    pulseStart(); xe = xB; expectWords(xe, muB, 3);
    // R6: raw pair, then masked against it
    muA = rndMu(); xA = rndX();
    loadPair(muA, xA, 0);
    pulseStart(); xe = xA; expectWords(xe, muA, 3);
    // R8: loading while running does not disturb
    muB = rndMu(); xB = rndX();
    loadPair(muB, xB, 1);
    expectWords(xe, muA, 3);
    // R7: restart picks up stored seeds
    pulseStart(); xe = xB; expectWords(xe, muB, 3);
    expectWords(xe, muB, 1);
    pulseStart(); xe = xB; expectWords(xe, muB, 2);

    // directed corners: extreme mu and x
    loadPair(26'h3_FFFFFF, 24'h000001, 1);
    pulseStart(); xe = 24'h000001; expectWords(xe, 26'h3_FFFFFF, 4);
    loadPair(26'h3_000001, 24'hFFFFFF, 0);
    pulseStart(); xe = 24'hFFFFFF; expectWords(xe, 26'h3_000001, 3);
    loadPair(26'h3_FFFFFF, 24'h800000, 1);
    pulseStart(); xe = 24'h800000; expectWords(xe, 26'h3_FFFFFF, 3);

    // random runs
    for (int r = 0; r < 8; r++) begin
      logic m;
      muA = rndMu(); xA = rndX(); m = 1'($urandom % 2);
      loadPair(muA, xA, m);
      pulseStart(); xe = xA; expectWords(xe, muA, 5);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule